// File: doc/BRIEF.md
# CPU Clock Divisor and Source Controller

This block sets the pace of a small processor core. It runs on the system clock and turns a programmed speed setting into a core clock enable that fires once every N system cycles. Software writes an 8-bit speed setting that holds a divisor code, a source select, two power-down bits for the oscillator and the PLL, and a core-stop bit. When the core fetches from slow flash, the divisor in use is raised to a flash minimum. When it fetches from program RAM, the programmed divisor applies unchanged.

A new divisor is taken up only at an instruction boundary, so the instruction that performs the write finishes at its old pace. Powering a clock source back up, or switching from one source to the other, holds the system clock in a suspended state for a fixed number of cycles. Two stop levels exist. The core-stop bit gates only the core. Turning off the clock source that is in use gates the whole system clock. The oscillator and PLL are modelled only through these enable bits.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: The speed setting is decoded as follows. Bits [3:0] are the divisor code: codes 0 to 12 give divide-by-(code+2), and codes 13 to 15 give divide-by-1, so 0x6 gives 8 and 0xD gives 1. Bit 4 selects the PLL as source (0 selects the oscillator). Bit 5 turns the oscillator off, bit 6 turns the PLL off and bit 7 stops the core.
- R2: With in_flash low, the divisor taken up is the programmed one. With in_flash high, it is the larger of the programmed divisor and flash_min_div.
- R3: spd_rdata shows the last value written, one cycle after the write. It never shows that the flash minimum is overriding the divisor, and it holds its value when no write occurs.
- R4: A boundary is a cycle in which both core_en and instr_done are high. A new divisor, fetch region or flash minimum takes effect only at the next boundary. The instruction in progress keeps the old spacing, and the next one uses the new spacing with no extra gap.
- R5: While the core is running, core_en pulses once every N system cycles, where N is the divisor taken up at the last boundary.
- R6: After reset the speed setting is 0x06, suspended is low, sys_en is high, and the first core_en pulse arrives in the 15th cycle after reset is released (divisor 2^DIV_W-1).
- R7: A write that clears bit 5 while it was set raises suspended for exactly 2^(osc_wud+4) cycles. During that time sys_en and core_en stay low.
- R8: A write that clears bit 6 while it was set, with the oscillator not restarting in the same write, raises suspended for exactly 2^(pll_wud+4) cycles.
- R9: If one write clears both bit 5 and bit 6, the suspension lasts 2^(osc_wud+4) cycles, and pll_wud has no effect.
- R10: A write that changes bit 4 and restarts no source raises suspended for exactly SRC_STALL cycles. A PLL restart in the same write takes priority over this stall.
- R11: While bit 7 is set, core_en stays low and sys_en stays high. Core pulses resume after bit 7 is cleared.
- R12: sys_en and core_en are low whenever the oscillator is off, or whenever the PLL is the selected source and the PLL is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spd_we | input | 1 | Speed-setting write strobe |
| spd_wdata | input | 8 | Speed setting to write |
| instr_done | input | 1 | Core signals the end of an instruction |
| in_flash | input | 1 | Next fetch comes from flash |
| flash_min_div | input | DIV_W | Smallest divisor that flash access allows |
| osc_wud | input | WUD_W | Oscillator wake-delay code (static) |
| pll_wud | input | WUD_W | PLL wake-delay code (static) |
| spd_rdata | output | 8 | Programmed speed setting, read back |
| core_en | output | 1 | Core clock enable pulse |
| sys_en | output | 1 | System clock enable |
| suspended | output | 1 | System clock held while a source restarts or switches |

## Verification
The bench builds the block with DIV_W=4, WUD_W=3 and SRC_STALL=3. With these values every divisor code, both fetch regions and all sixteen flash minimums can be swept together, and every spacing is measured from one core pulse to the next. The 3-bit wake fields keep the longest suspension at 2048 cycles, so every oscillator and PLL delay code can be counted out cycle by cycle. A stall of 3 keeps the source-switch window short enough to check against the PLL-restart priority.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;

    typedef struct packed {
        logic       core_stop;
        logic       pll_off;
        logic       osc_off;
        logic       src_pll;
        logic [3:0] code;
    } spd_t;

    localparam logic [7:0] SPD_RESET = 8'h06;
    localparam int unsigned CODE_W   = 4;

    function automatic logic [CODE_W-1:0] code_to_div(input logic [CODE_W-1:0] c);
        if (c >= 4'd13) return 4'd1;
        return c + 4'd2;
    endfunction

endpackage

// File: rtl/clk_div_sel.sv
module clk_div_sel
    import cpu_clk_pkg::*;
#(
    parameter int unsigned DIV_W = 4
) (
    input  logic [CODE_W-1:0] code,
    input  logic              in_flash,
    input  logic [DIV_W-1:0]  flash_min,
    output logic [DIV_W-1:0]  eff_div
);
    logic [DIV_W-1:0] prog_div;

    always_comb begin
        prog_div = DIV_W'(code_to_div(code));
        if (in_flash && (flash_min > prog_div)) eff_div = flash_min;
        else                                    eff_div = prog_div;
    end
endmodule

// File: rtl/clk_cadence.sv
module clk_cadence #(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             boundary,
    input  logic [DIV_W-1:0] next_div,
    output logic             core_en
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
    } cad_t;

    cad_t st_d, st_q;

    assign core_en = run && (st_q.cnt == (st_q.div - DIV_W'(1)));

    always_comb begin
        st_d = st_q;
        if (run) begin
            if (core_en) begin
                st_d.cnt = '0;
                if (boundary) st_d.div = next_div;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.div <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/clk_wake_seq.sv
module clk_wake_seq
    import cpu_clk_pkg::*;
#(
    parameter int unsigned WUD_W     = 3,
    parameter int unsigned SRC_STALL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  spd_t             old_v,
    input  spd_t             new_v,
    input  logic [WUD_W-1:0] osc_wud,
    input  logic [WUD_W-1:0] pll_wud,
    output logic             suspended
);
    localparam int unsigned CNT_W = (1 << WUD_W) + 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wk_t;

    wk_t st_d, st_q;
    logic osc_wake, pll_wake, src_swap;

    assign suspended = (st_q.cnt != '0);

    always_comb begin
        osc_wake = we && old_v.osc_off && !new_v.osc_off;
        pll_wake = we && old_v.pll_off && !new_v.pll_off;
        src_swap = we && (old_v.src_pll != new_v.src_pll);
        st_d     = st_q;
        if (osc_wake)      st_d.cnt = CNT_W'(1) << (32'(osc_wud) + 4);
        else if (pll_wake) st_d.cnt = CNT_W'(1) << (32'(pll_wud) + 4);
        else if (src_swap) st_d.cnt = CNT_W'(SRC_STALL);
        else if (suspended) st_d.cnt = st_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cpu_clk_ctrl.sv
module cpu_clk_ctrl
    import cpu_clk_pkg::*;
#(
    parameter int unsigned DIV_W     = 4,
    parameter int unsigned WUD_W     = 3,
    parameter int unsigned SRC_STALL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spd_we,
    input  logic [7:0]       spd_wdata,
    input  logic             instr_done,
    input  logic             in_flash,
    input  logic [DIV_W-1:0] flash_min_div,
    input  logic [WUD_W-1:0] osc_wud,
    input  logic [WUD_W-1:0] pll_wud,
    output logic [7:0]       spd_rdata,
    output logic             core_en,
    output logic             sys_en,
    output logic             suspended
);
    typedef struct packed {
        spd_t spd;
    } top_t;

    top_t st_d, st_q;
    logic [DIV_W-1:0] eff_div;
    logic src_live, run;

    always_comb begin
        st_d = st_q;
        if (spd_we) st_d.spd = spd_t'(spd_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.spd <= spd_t'(SPD_RESET);
        else        st_q     <= st_d;
    end

    assign spd_rdata = st_q.spd;
    assign src_live  = !st_q.spd.osc_off && !(st_q.spd.src_pll && st_q.spd.pll_off);
    assign sys_en    = !suspended && src_live;
    assign run       = sys_en && !st_q.spd.core_stop;

    clk_div_sel #(.DIV_W(DIV_W)) u_sel (
        .code      (st_d.spd.code),
        .in_flash  (in_flash),
        .flash_min (flash_min_div),
        .eff_div   (eff_div)
    );

    clk_cadence #(.DIV_W(DIV_W)) u_cad (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .boundary (instr_done),
        .next_div (eff_div),
        .core_en  (core_en)
    );

    clk_wake_seq #(.WUD_W(WUD_W), .SRC_STALL(SRC_STALL)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (spd_we),
        .old_v     (st_q.spd),
        .new_v     (st_d.spd),
        .osc_wud   (osc_wud),
        .pll_wud   (pll_wud),
        .suspended (suspended)
    );
endmodule

// File: rtl/clk_ctrl_chk.sv
module clk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spd_we,
    input logic [7:0] spd_wdata,
    input logic [7:0] spd_rdata,
    input logic       core_en,
    input logic       sys_en,
    input logic       suspended
);
    assert_core_in_sys_R12: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> sys_en);
    assert_stop_gates_R11: assert property (@(posedge clk) disable iff (!rst_n)
        spd_rdata[7] |-> !core_en);
    assert_susp_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> (!sys_en && !core_en));
    assert_rdata_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spd_we |=> (spd_rdata == $past(spd_wdata)));
    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !spd_we |=> $stable(spd_rdata));
    assert_osc_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_we && spd_rdata[5] && !spd_wdata[5]) |=> suspended);
    assert_pll_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_we && spd_rdata[6] && !spd_wdata[6]) |=> suspended);
    assert_osc_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        spd_rdata[5] |-> !sys_en);
endmodule

bind cpu_clk_ctrl clk_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spd_we    (spd_we),
    .spd_wdata (spd_wdata),
    .spd_rdata (spd_rdata),
    .core_en   (core_en),
    .sys_en    (sys_en),
    .suspended (suspended)
);

// File: tb/cpu_clk_ctrl_tb.sv
module cpu_clk_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spd_we = 1'b0;
    logic [7:0] spd_wdata = 8'h00;
    logic       instr_done = 1'b0;
    logic       in_flash = 1'b0;
    logic [3:0] flash_min_div = 4'd0;
    logic [2:0] osc_wud = 3'd0;
    logic [2:0] pll_wud = 3'd0;
    logic [7:0] spd_rdata;
    logic       core_en, sys_en, suspended;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cpu_clk_ctrl #(.DIV_W(4), .WUD_W(3), .SRC_STALL(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .spd_we(spd_we), .spd_wdata(spd_wdata),
        .instr_done(instr_done), .in_flash(in_flash), .flash_min_div(flash_min_div),
        .osc_wud(osc_wud), .pll_wud(pll_wud), .spd_rdata(spd_rdata),
        .core_en(core_en), .sys_en(sys_en), .suspended(suspended)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_div(input int code, input int fl, input int fm);
        int d;
        d = (code >= 13) ? 1 : code + 2;
        if (fl != 0 && fm > d) d = fm;
        return d;
    endfunction

    task automatic wait_core();
        int g = 0;
        while (!core_en && g < 300) begin
            @(negedge clk);
            g++;
        end
    endtask

    // Called at a negedge where core_en is high; drives one cycle, returns spacing to next pulse.
    task automatic step(input logic we, input logic [7:0] v, input logic bd, output int gap);
        spd_we = we;
        spd_wdata = v;
        instr_done = bd;
        gap = 0;
        do begin
            @(negedge clk);
            spd_we = 1'b0;
            instr_done = 1'b0;
            gap++;
        end while (!core_en && gap < 100);
    endtask

    task automatic plain_write(input logic [7:0] v);
        @(negedge clk);
        spd_wdata = v;
        spd_we = 1'b1;
        instr_done = 1'b0;
        @(negedge clk);
        spd_we = 1'b0;
    endtask

    task automatic count_susp(output int n, output int leak);
        n = 0;
        leak = 0;
        while (suspended && n < 5000) begin
            if (sys_en || core_en) leak = 1;
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int gap, n, leak, pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6 reset state
        chk("R6 rdata", spd_rdata, 8'h06);
        chk("R6 suspended", suspended, 0);
        chk("R6 sys_en", sys_en, 1);
        gap = 1;
        while (!core_en && gap < 100) begin
            @(negedge clk);
            gap++;
        end
        chk("R6 first pulse", gap, 15);

        // R1 R2 R5 sweep over codes, region and flash minimum
        for (int c = 0; c < 16; c++) begin
            for (int fl = 0; fl < 2; fl++) begin
                for (int fm = 0; fm < 16; fm++) begin
                    in_flash = fl[0];
                    flash_min_div = fm[3:0];
                    wait_core();
                    step(1'b1, {4'h0, c[3:0]}, 1'b1, gap);
                    chk("R1 R2 divisor", gap, exp_div(c, fl, fm));
                    chk("R3 readback", spd_rdata, c);
                    step(1'b0, 8'h00, 1'b0, gap);
                    chk("R5 cadence", gap, exp_div(c, fl, fm));
                end
            end
        end

        // R4 boundary timing
        in_flash = 1'b0;
        flash_min_div = 4'd0;
        wait_core();
        step(1'b1, 8'h06, 1'b1, gap);
        chk("R4 to div8", gap, 8);
        step(1'b1, 8'h0D, 1'b0, gap);
        chk("R4 no boundary keeps old", gap, 8);
        chk("R3 readback no override", spd_rdata, 8'h0D);
        step(1'b0, 8'h00, 1'b1, gap);
        chk("R4 boundary takes new", gap, 1);
        in_flash = 1'b1;
        flash_min_div = 4'd12;
        step(1'b0, 8'h00, 1'b0, gap);
        chk("R4 region waits for boundary", gap, 1);
        step(1'b0, 8'h00, 1'b1, gap);
        chk("R2 flash minimum applied", gap, 12);
        chk("R3 rdata unchanged by flash", spd_rdata, 8'h0D);
        in_flash = 1'b0;

        // R12 system stop
        plain_write(8'h7D);
        repeat (3) @(negedge clk);
        chk("R12 sys_en off", sys_en, 0);
        chk("R12 core_en off", core_en, 0);
        chk("R12 not suspended", suspended, 0);

        // R9 both sources restart together
        for (int w = 0; w < 8; w++) begin
            osc_wud = w[2:0];
            pll_wud = 3'(7 - w);
            plain_write(8'h7D);
            plain_write(8'h0D);
            count_susp(n, leak);
            chk("R9 joint wake length", n, 1 << (w + 4));
            chk("R7 gated while suspended", leak, 0);
            chk("R9 sys_en after", sys_en, 1);
        end

        // R7 oscillator restart
        pll_wud = 3'd7;
        for (int w = 0; w < 4; w++) begin
            osc_wud = w[2:0];
            plain_write(8'h2D);
            plain_write(8'h0D);
            count_susp(n, leak);
            chk("R7 osc wake length", n, 1 << (w + 4));
        end

        // R8 PLL restart
        osc_wud = 3'd0;
        for (int w = 0; w < 8; w++) begin
            pll_wud = w[2:0];
            plain_write(8'h4D);
            plain_write(8'h0D);
            count_susp(n, leak);
            chk("R8 pll wake length", n, 1 << (w + 4));
            chk("R8 gated while suspended", leak, 0);
        end

        // R10 source switch
        plain_write(8'h0D);
        plain_write(8'h1D);
        count_susp(n, leak);
        chk("R10 switch to pll stall", n, 3);
        plain_write(8'h0D);
        count_susp(n, leak);
        chk("R10 switch to osc stall", n, 3);

        // R12 selected PLL off, then R10 priority
        plain_write(8'h4D);
        chk("R12 osc source pll off runs", sys_en, 1);
        plain_write(8'h5D);
        count_susp(n, leak);
        chk("R10 stall into dead pll", n, 3);
        repeat (5) @(negedge clk);
        chk("R12 pll source off", sys_en, 0);
        pll_wud = 3'd2;
        plain_write(8'h0D);
        count_susp(n, leak);
        chk("R10 pll wake beats stall", n, 64);

        // R11 core stop
        plain_write(8'h8D);
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            if (core_en) pulses++;
            if (!sys_en) leak = 1;
            @(negedge clk);
        end
        chk("R11 no core pulses", pulses, 0);
        chk("R11 sys_en kept", sys_en, 1);
        plain_write(8'h0D);
        pulses = 0;
        for (int i = 0; i < 30; i++) begin
            if (core_en) pulses++;
            @(negedge clk);
        end
        chk("R11 resumes", (pulses > 0) ? 1 : 0, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule